// File: doc/BRIEF.md
# Multi-sector disk address sequencer

This block steps the disk address through a multi-sector read or write. A start pulse captures five parameter bytes: the drive, the head with the upper cylinder bits, the lower cylinder byte, the first sector and the sector count. It then waits for the media side to report each finished sector. After every sector the remaining count drops by one. While sectors remain, the address moves on in nested order: the sector number first, then the head, then the cylinder. A head change and a cylinder change each raise a one-cycle indication, so that the drive logic knows it must select a new head or seek.

A fixed 1024-byte buffer sits between the host and the media. The sector-size code sets how many sectors fit in one buffer load. On a read, sectors collect until the buffer is full or the count runs out, and then a host transfer is requested. On a write, a host transfer is requested first, and again each time the loaded sectors have been written, until the count runs out. The geometry limits are inputs: sectors per track, last head and highest cylinder.

When the run ends, a one-cycle completion pulse is given and four result bytes are presented: the current head and upper cylinder bits, the lower cylinder byte, the number of the last sector handled, and the residual count. The run can end in three ways: normally, by an external error, or by an attempt to move past the highest cylinder.

Top module: `msec_addr_seq`

## Requirements
- R1: While idle, a `start` pulse loads the drive from `prm0[1:0]`, the head from `prm1[6:4]`, the cylinder from `{prm1[3:0], prm2}`, the first sector from `prm3[6:0]` and the count from `prm4[6:0]`. With a non-zero count, `busy` is high from the next cycle and `seek_req` pulses for one cycle.
- R2: Each `sector_done` taken while busy and not requesting a transfer lowers the count by one. If the new count is non-zero, the sector number advances by one, modulo `spt`.
- R3: When the sector number wraps to 0 and the head is below `last_head`, the head increments and `head_chg` pulses for one cycle with `seek_req` low.
- R4: When the sector number wraps to 0 at `last_head`, the head returns to 0, the cylinder increments and `seek_req` pulses for one cycle.
- R5: `size_sel` values 0, 1, 2 and 3 (128, 256, 512 and 1024 bytes per sector) give a buffer capacity of 8, 4, 2 and 1 sectors.
- R6: Read (`wr_mode`=0): `xfer_req` rises after the sector that fills the buffer or brings the count to zero, and it stays high until `xfer_done`. After the final transfer, `done` pulses for one cycle.
- R7: Write (`wr_mode`=1): `xfer_req` is high straight after start. After each `xfer_done`, up to one buffer's worth of sectors is written before `xfer_req` returns. `done` pulses right after the sector that brings the count to zero, with no further transfer.
- R8: Result bytes: `res1` = {0, head[2:0], cyl[11:8]}, `res2` = cyl[7:0], `res3` = {0, last sector handled}, `res4` = {0, residual count}.
- R9: `err_in` while busy ends the run on the next edge with `done` and `err_flag`. It takes priority over a simultaneous `sector_done`, so the residual count is frozen.
- R10: A cylinder step that would pass `max_cyl` ends the run with `done` and `illegal`. The address is not advanced, and the residual is the count after that sector.
- R11: A start with a count of 0 gives `done` on the next cycle, never raises `xfer_req` and reports a residual of 0.
- R12: `sector_done`, `xfer_done` and `err_in` while idle change neither the result bytes nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| wr_mode | input | 1 | 1 = write run, 0 = read run |
| prm0 | input | 8 | Drive number in bits 1:0 |
| prm1 | input | 8 | Head in 6:4, cylinder 11:8 in 3:0 |
| prm2 | input | 8 | Cylinder 7:0 |
| prm3 | input | 8 | First sector in 6:0 |
| prm4 | input | 8 | Sector count in 6:0 |
| size_sel | input | 2 | Sector size code 0..3 = 128..1024 bytes |
| spt | input | 7 | Sectors per track |
| last_head | input | 3 | Highest head number |
| max_cyl | input | 12 | Highest cylinder number |
| sector_done | input | 1 | Media finished one sector |
| xfer_done | input | 1 | Host finished the buffer transfer |
| err_in | input | 1 | Unrecovered error, abort |
| busy | output | 1 | Run in progress |
| xfer_req | output | 1 | Host buffer transfer requested |
| seek_req | output | 1 | One-cycle: cylinder (re)positioning needed |
| head_chg | output | 1 | One-cycle: head changed within cylinder |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Last run ended by `err_in` |
| illegal | output | 1 | Last run ended on a cylinder overflow |
| drive | output | 2 | Captured drive number |
| res1 | output | 8 | Head and upper cylinder result |
| res2 | output | 8 | Lower cylinder result |
| res3 | output | 8 | Last sector result |
| res4 | output | 8 | Residual count result |

## Verification
The assertions take for granted that the geometry inputs stay constant during a run, that the starting head does not exceed `last_head`, and that the starting sector is below `spt`. The head-range property depends on these. They also assume the media side pulses `sector_done` only when no transfer is pending. The directed bench sets the geometry before each start and leaves it alone for the whole run. Its responder answers a pending `xfer_req` with `xfer_done` and otherwise pulses `sector_done` only while busy. Starting addresses are always taken inside the stated geometry.

// File: rtl/msec_addr_seq.sv
module msec_addr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr_mode,
  input  logic [7:0]  prm0,
  input  logic [7:0]  prm1,
  input  logic [7:0]  prm2,
  input  logic [7:0]  prm3,
  input  logic [7:0]  prm4,
  input  logic [1:0]  size_sel,
  input  logic [6:0]  spt,
  input  logic [2:0]  last_head,
  input  logic [11:0] max_cyl,
  input  logic        sector_done,
  input  logic        xfer_done,
  input  logic        err_in,
  output logic        busy,
  output logic        xfer_req,
  output logic        seek_req,
  output logic        head_chg,
  output logic        done,
  output logic        err_flag,
  output logic        illegal,
  output logic [1:0]  drive,
  output logic [7:0]  res1,
  output logic [7:0]  res2,
  output logic [7:0]  res3,
  output logic [7:0]  res4
);
  typedef enum logic [1:0] {S_IDLE, S_MEDIA, S_XFER, S_DONE} st_t;

  st_t         st;
  logic [11:0] cyl;
  logic [2:0]  head;
  logic [6:0]  sec, cnt, last_sec;
  logic [3:0]  inbuf;
  logic        mode_wr;

  logic [3:0]  per_buf;
  logic [6:0]  cnt_dec;
  logic        sec_wrap, at_last_head, cyl_over;
  logic [3:0]  inbuf_rd, inbuf_wr, wr_load;

  assign per_buf      = 4'd8 >> size_sel;
  assign cnt_dec      = cnt - 7'd1;
  assign sec_wrap     = ({1'b0, sec} + 8'd1) >= {1'b0, spt};
  assign at_last_head = head == last_head;
  assign cyl_over     = sec_wrap && at_last_head && (cyl == max_cyl);
  assign inbuf_rd     = inbuf + 4'd1;
  assign inbuf_wr     = inbuf - 4'd1;
  assign wr_load      = ({1'b0, cnt} < {4'd0, per_buf}) ? cnt[3:0] : per_buf;

  assign busy     = (st == S_MEDIA) || (st == S_XFER);
  assign xfer_req = st == S_XFER;
  assign done     = st == S_DONE;
  assign res1     = {1'b0, head, cyl[11:8]};
  assign res2     = cyl[7:0];
  assign res3     = {1'b0, last_sec};
  assign res4     = {1'b0, cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cyl      <= '0;
      head     <= '0;
      sec      <= '0;
      cnt      <= '0;
      last_sec <= '0;
      inbuf    <= '0;
      mode_wr  <= 1'b0;
      drive    <= '0;
      seek_req <= 1'b0;
      head_chg <= 1'b0;
      err_flag <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      seek_req <= 1'b0;
      head_chg <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          drive    <= prm0[1:0];
          head     <= prm1[6:4];
          cyl      <= {prm1[3:0], prm2};
          sec      <= prm3[6:0];
          last_sec <= prm3[6:0];
          cnt      <= prm4[6:0];
          mode_wr  <= wr_mode;
          inbuf    <= '0;
          err_flag <= 1'b0;
          illegal  <= 1'b0;
          if (prm4[6:0] == 7'd0) st <= S_DONE;
          else begin
            seek_req <= 1'b1;
            st       <= wr_mode ? S_XFER : S_MEDIA;
          end
        end
        S_MEDIA: begin
          if (err_in) begin
            err_flag <= 1'b1;
            st       <= S_DONE;
          end else if (sector_done) begin
            cnt      <= cnt_dec;
            last_sec <= sec;
            inbuf    <= mode_wr ? inbuf_wr : inbuf_rd;
            if (cnt_dec == 7'd0) begin
              st <= mode_wr ? S_DONE : S_XFER;
            end else if (cyl_over) begin
              illegal <= 1'b1;
              st      <= S_DONE;
            end else begin
              if (sec_wrap) begin
                sec <= '0;
                if (at_last_head) begin
                  head     <= '0;
                  cyl      <= cyl + 12'd1;
                  seek_req <= 1'b1;
                end else begin
                  head     <= head + 3'd1;
                  head_chg <= 1'b1;
                end
              end else begin
                sec <= sec + 7'd1;
              end
              if (mode_wr) st <= (inbuf_wr == 4'd0) ? S_XFER : S_MEDIA;
              else         st <= (inbuf_rd == per_buf) ? S_XFER : S_MEDIA;
            end
          end
        end
        S_XFER: begin
          if (err_in) begin
            err_flag <= 1'b1;
            st       <= S_DONE;
          end else if (xfer_done) begin
            if (mode_wr) begin
              inbuf <= wr_load;
              st    <= S_MEDIA;
            end else begin
              inbuf <= '0;
              st    <= (cnt == 7'd0) ? S_DONE : S_MEDIA;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msec_addr_seq_chk.sv
module msec_addr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  last_head,
  input logic        sector_done,
  input logic        err_in,
  input logic        busy,
  input logic        xfer_req,
  input logic        seek_req,
  input logic        head_chg,
  input logic        done,
  input logic        err_flag,
  input logic [7:0]  res1,
  input logic [7:0]  res4
);
  assert_xfer_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> busy);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_head_or_seek_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(seek_req && head_chg));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_req && sector_done && !err_in) |=> (res4 == $past(res4) - 8'd1));

  assert_err_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_in) |=> (done && err_flag && res4 == $past(res4)));

  assert_head_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (res1[6:4] <= last_head));

  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> (busy || done));
endmodule

bind msec_addr_seq msec_addr_seq_chk u_chk (.*);

// File: tb/tb_msec_addr_seq.sv
`timescale 1ns/1ps
module tb_msec_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr_mode = 0;
  logic [7:0] prm0 = 0, prm1 = 0, prm2 = 0, prm3 = 0, prm4 = 0;
  logic [1:0] size_sel = 0;
  logic [6:0] spt = 7'd18;
  logic [2:0] last_head = 3'd3;
  logic [11:0] max_cyl = 12'd100;
  logic sector_done = 0, xfer_done = 0, err_in = 0;
  logic busy, xfer_req, seek_req, head_chg, done, err_flag, illegal;
  logic [1:0] drive;
  logic [7:0] res1, res2, res3, res4;

  int tests = 0, fails = 0;
  int n_seek = 0, n_hchg = 0, n_xfer = 0;
  logic xfer_prev = 0;

  always #4 clk = ~clk;

  msec_addr_seq dut (.*);

  always @(negedge clk) begin
    if (seek_req) n_seek++;
    if (head_chg) n_hchg++;
    if (xfer_req && !xfer_prev) n_xfer++;
    xfer_prev = xfer_req;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go(input logic wr, input logic [1:0] sz, input logic [7:0] p0, p1, p2, p3, p4);
    @(negedge clk);
    wr_mode = wr; size_sel = sz;
    prm0 = p0; prm1 = p1; prm2 = p2; prm3 = p3; prm4 = p4;
    n_seek = 0; n_hchg = 0; n_xfer = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic service(input int max_sectors, output logic saw_done);
    int secs = 0;
    saw_done = 0;
    if (done) begin saw_done = 1; return; end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      sector_done = 0; xfer_done = 0;
      if (done) begin saw_done = 1; return; end
      if (xfer_req) xfer_done = 1;
      else if (busy) begin
        if (secs == max_sectors) return;
        sector_done = 1; secs++;
      end
    end
  endtask

  task automatic t_reset();
    check("R8 reset busy", busy, 0);
    check("R8 reset xfer_req", xfer_req, 0);
    check("R8 reset res1", res1, 0);
    check("R8 reset res4", res4, 0);
  endtask

  task automatic t_read_head_step();
    logic d;
    spt = 7'd4; last_head = 3'd1; max_cyl = 12'd100;
    go(0, 2'd2, 8'd3, 8'h00, 8'd5, 8'd2, 8'd5);
    check("R1 busy after start", busy, 1);
    check("R1 drive", drive, 3);
    check("R1 start sector in res3", res3, 2);
    service(100, d);
    check("R6 read done", d, 1);
    check("R5 R6 512-byte read transfers", n_xfer, 3);
    check("R3 head changes", n_hchg, 1);
    check("R1 start seek only", n_seek, 1);
    check("R8 res1 head1 cyl5", res1, 8'h10);
    check("R8 res2", res2, 5);
    check("R8 res3 last sector", res3, 2);
    check("R8 res4 residual", res4, 0);
  endtask

  task automatic t_read_cyl_roll();
    logic d;
    spt = 7'd2; last_head = 3'd0; max_cyl = 12'd300;
    go(0, 2'd3, 8'd1, 8'h01, 8'd7, 8'd1, 8'd2);
    service(100, d);
    check("R4 done", d, 1);
    check("R4 seek pulses", n_seek, 2);
    check("R4 no head_chg", n_hchg, 0);
    check("R5 1024-byte read transfers", n_xfer, 2);
    check("R4 res1 head0 cyl high 1", res1, 8'h01);
    check("R4 res2 cylinder low", res2, 8);
    check("R2 res3 wrapped sector", res3, 0);
  endtask

  task automatic t_read_size128();
    logic d;
    spt = 7'd18; last_head = 3'd3; max_cyl = 12'd100;
    go(0, 2'd0, 8'd0, 8'h20, 8'd9, 8'd0, 8'd10);
    service(100, d);
    check("R5 128-byte read transfers", n_xfer, 2);
    check("R2 res3 after 10 sectors", res3, 9);
    check("R2 head unchanged", res1, 8'h20);
  endtask

  task automatic t_write_small();
    logic d;
    spt = 7'd18; last_head = 3'd3; max_cyl = 12'd100;
    go(1, 2'd0, 8'd2, 8'h10, 8'd4, 8'd5, 8'd3);
    check("R7 xfer_req right after start", xfer_req, 1);
    service(100, d);
    check("R7 write done", d, 1);
    check("R7 single transfer", n_xfer, 1);
    check("R7 res3", res3, 7);
    check("R7 residual", res4, 0);
  endtask

  task automatic t_write_big();
    logic d;
    spt = 7'd18; last_head = 3'd3; max_cyl = 12'd100;
    go(1, 2'd3, 8'd0, 8'h00, 8'd1, 8'd17, 8'd2);
    service(100, d);
    check("R7 R5 1024-byte write transfers", n_xfer, 2);
    check("R3 write head step", n_hchg, 1);
    check("R7 res1 head1", res1, 8'h10);
    check("R7 res3", res3, 0);
  endtask

  task automatic t_error();
    logic d;
    spt = 7'd18; last_head = 3'd3; max_cyl = 12'd100;
    go(0, 2'd0, 8'd0, 8'h00, 8'd3, 8'd0, 8'd6);
    service(2, d);
    @(negedge clk);
    sector_done = 1; err_in = 1;
    @(negedge clk);
    sector_done = 0; err_in = 0;
    check("R9 done after error", done, 1);
    check("R9 err_flag", err_flag, 1);
    check("R9 frozen residual", res4, 4);
    check("R9 illegal low", illegal, 0);
  endtask

  task automatic t_illegal();
    logic d;
    spt = 7'd4; last_head = 3'd1; max_cyl = 12'd9;
    go(0, 2'd1, 8'd0, 8'h10, 8'd9, 8'd3, 8'd3);
    service(100, d);
    check("R10 done", d, 1);
    check("R10 illegal", illegal, 1);
    check("R10 residual", res4, 2);
    check("R10 cylinder kept", res2, 9);
    check("R10 no extra seek", n_seek, 1);
  endtask

  task automatic t_zero();
    @(negedge clk);
    prm4 = 0; wr_mode = 0; n_xfer = 0; start = 1;
    @(negedge clk);
    start = 0;
    check("R11 done next cycle", done, 1);
    @(negedge clk);
    check("R11 no transfer", n_xfer, 0);
    check("R11 residual", res4, 0);
  endtask

  task automatic t_idle_ignore();
    logic [7:0] r3, r4;
    r3 = res3; r4 = res4;
    @(negedge clk); sector_done = 1; xfer_done = 1; err_in = 1;
    @(negedge clk); sector_done = 0; xfer_done = 0; err_in = 0;
    @(negedge clk);
    check("R12 idle busy", busy, 0);
    check("R12 idle res3", res3, r3);
    check("R12 idle res4", res4, r4);
    check("R12 idle err_flag", err_flag, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_head_step();
    t_read_cyl_roll();
    t_read_size128();
    t_write_small();
    t_write_big();
    t_error();
    t_illegal();
    t_zero();
    t_idle_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule